// File: doc/BRIEF.md
# Sparse Fanout Spike Router

This block turns one spike from a source neuron into a series of delivery events, one for each target that the source feeds. It serves a fabric of 16 neuron groups with 128 neurons each. A source is named by an 11-bit global ID. The group number sits in the upper four bits and the local index in the lower seven: `{group[3:0], local[6:0]}`. Each source owns 16 fanout slots in a connectivity table. A slot holds a live flag, a target group, a target local neuron, an 8-bit weight and an excitatory/inhibitory flag.

Software fills the table one slot at a time through the write port. The table is not cleared at power-up, so every slot of a source must be written, or written dead, before that source may spike. A spike arrives on a valid/ready input. The router then reads the source's whole slot row, which takes one cycle of memory latency, and keeps a private copy of it. It then presents the live slots on a valid/ready delivery port in ascending slot order. Downstream backpressure holds the current delivery in place. No new spike is taken until the last delivery of the current one has been handshaked.

The scan controller has three states:
- `S_IDLE` raises input ready. A spike handshake issues the row read and moves to `S_FETCH`.
- `S_FETCH` captures the row. It moves to `S_SEND` if any slot is live, or back to `S_IDLE` if none is.
- `S_SEND` presents the lowest pending slot. Each delivery handshake retires that slot. When the retired slot was the last pending one, the controller returns to `S_IDLE`.

Top module: `spike_fanout_router`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A spike yields exactly one delivery per slot whose live flag (entry bit 20, the MSB) is 1, in ascending slot order. Dead slots yield nothing.
- R3: Each delivery carries the stored fields of its slot: `out_group`, `out_neuron`, `out_weight` and `out_exc`.
- R4: `in_ready` is 0 from the cycle after a spike is accepted until the cycle after the last delivery handshake, and is 1 again then.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and all delivery fields hold their values.
- R6: A source with no live slot consumes its spike, produces no delivery, and raises `in_ready` again two cycles after acceptance.
- R7: The cycle after acceptance shows `out_valid` 0 (row fetch). The first delivery appears in the second cycle after acceptance.
- R8: A table write made while a spike is being scanned does not alter that spike's deliveries. The next spike from that source sees the write.
- R9: A write replaces only the addressed slot of the addressed source. All other slots and sources keep their contents.
- R10: A source with all 16 slots live produces 16 back-to-back deliveries under constant `out_ready`.
- R11: Two sources that share a local index but differ in group bits (ID bits 10:7) address separate slot rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Spike offered |
| in_ready | output | 1 | Router can take a spike |
| in_src | input | 11 | Global source ID {group, local} |
| wr_en | input | 1 | Table write strobe |
| wr_src | input | 11 | Source whose slot is written |
| wr_slot | input | 4 | Slot index written |
| wr_dst_group | input | 4 | Target group stored in the slot |
| wr_dst_neuron | input | 7 | Target local neuron stored in the slot |
| wr_weight | input | 8 | Synaptic weight stored in the slot |
| wr_exc | input | 1 | 1 = excitatory, 0 = inhibitory |
| wr_live | input | 1 | Live flag stored in the slot |
| out_valid | output | 1 | Delivery offered |
| out_ready | input | 1 | Receiver takes the delivery |
| out_group | output | 4 | Target group |
| out_neuron | output | 7 | Target local neuron |
| out_weight | output | 8 | Synaptic weight |
| out_exc | output | 1 | Excitatory flag |

## Verification
The hardest case to reach is a table write that lands on the very source whose row is being scanned. In normal traffic the write port and the scan never overlap on one source. To force the overlap, the stimulus holds `out_ready` low on the first delivery of a two-slot source, which freezes the scan in `S_SEND`. It writes new contents into that source's second slot during the stall and then releases the receiver. The old second entry must still appear for the spike in flight. A second spike from the same source must then deliver the new entry.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_SEND  = 2'd2
    } scan_state_e;

endpackage

// File: rtl/sfr_slot_table.sv
// Connectivity table: one packed row of SLOTS entries per source.
// Writes update one entry lane; reads return the whole row one cycle later.
module sfr_slot_table #(
    parameter int SRC_W   = 11,
    parameter int SLOT_W  = 4,
    parameter int ENTRY_W = 21
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [SRC_W-1:0]            wr_src,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [ENTRY_W-1:0]          wr_entry,
    input  logic                        rd_en,
    input  logic [SRC_W-1:0]            rd_src,
    output logic [(ENTRY_W<<SLOT_W)-1:0] rd_row
);
    localparam int SLOTS = 1 << SLOT_W;
    localparam int ROW_W = ENTRY_W * SLOTS;
    localparam int DEPTH = 1 << SRC_W;

    logic [ROW_W-1:0] rows [DEPTH];

    // Lane write; other lanes of the row are untouched.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows[wr_src][int'(wr_slot)*ENTRY_W +: ENTRY_W] <= wr_entry;
        end
    end

    // Registered row read (read-before-write on a same-cycle collision).
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_row <= rows[rd_src];
        end
    end

endmodule

// File: rtl/sfr_first_live.sv
// Lowest-index set bit of a pending mask, as index and one-hot.
module sfr_first_live #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    logic found;

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx   = W'(i);
                found = 1'b1;
            end
        end
        onehot = found ? (N'(1) << idx) : '0;
    end

endmodule

// File: rtl/sfr_scan_fsm.sv
// Scan controller: accept, fetch row, serialise live slots.
module sfr_scan_fsm
    import sfr_pkg::*;
#(
    parameter int SLOT_W  = 4,
    parameter int ENTRY_W = 21
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    output logic                          rd_en,
    input  logic [(ENTRY_W<<SLOT_W)-1:0]  rd_row,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [ENTRY_W-2:0]            out_payload
);
    localparam int SLOTS = 1 << SLOT_W;
    localparam int ROW_W = ENTRY_W * SLOTS;
    localparam int PAY_W = ENTRY_W - 1;

    scan_state_e       state_q, state_d;
    logic [ROW_W-1:0]  row_q;
    logic [SLOTS-1:0]  pend_q;
    logic [SLOTS-1:0]  row_mask;
    logic [SLOTS-1:0]  pick_oh;
    logic [SLOTS-1:0]  rest;
    logic [SLOT_W-1:0] cur_idx;
    logic              load_row;
    logic              retire;

    // Live flags of the freshly read row (entry MSB).
    for (genvar s = 0; s < SLOTS; s++) begin : g_live
        assign row_mask[s] = rd_row[s*ENTRY_W + ENTRY_W - 1];
    end

    sfr_first_live #(
        .N (SLOTS),
        .W (SLOT_W)
    ) u_pick (
        .mask   (pend_q),
        .idx    (cur_idx),
        .onehot (pick_oh)
    );

    assign rest        = pend_q & ~pick_oh;
    assign out_payload = row_q[int'(cur_idx)*ENTRY_W +: PAY_W];

    // State and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pend_q  <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_row) begin
                row_q  <= rd_row;
                pend_q <= row_mask;
            end else if (retire) begin
                pend_q <= rest;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        rd_en     = 1'b0;
        out_valid = 1'b0;
        load_row  = 1'b0;
        retire    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    rd_en   = 1'b1;
                    state_d = S_FETCH;
                end
            end
            S_FETCH: begin
                load_row = 1'b1;
                state_d  = (|row_mask) ? S_SEND : S_IDLE;
            end
            S_SEND: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    retire = 1'b1;
                    if (rest == '0) begin
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Each handshake retires exactly one pending slot (R2).
    p_retire_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEND && out_ready)
        |=> ($countones(pend_q) == $countones($past(pend_q)) - 1))
        else $error("p_retire_one_r2");

    // Slots leave in strictly ascending order (R2).
    p_slot_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEND && out_ready)
        |=> (state_q != S_SEND || cur_idx > $past(cur_idx)))
        else $error("p_slot_order_r2");

endmodule

// File: rtl/spike_fanout_router.sv
module spike_fanout_router #(
    parameter int GROUP_W  = 4,
    parameter int LOCAL_W  = 7,
    parameter int SLOT_W   = 4,
    parameter int WEIGHT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [GROUP_W+LOCAL_W-1:0] in_src,
    input  logic                       wr_en,
    input  logic [GROUP_W+LOCAL_W-1:0] wr_src,
    input  logic [SLOT_W-1:0]          wr_slot,
    input  logic [GROUP_W-1:0]         wr_dst_group,
    input  logic [LOCAL_W-1:0]         wr_dst_neuron,
    input  logic [WEIGHT_W-1:0]        wr_weight,
    input  logic                       wr_exc,
    input  logic                       wr_live,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [GROUP_W-1:0]         out_group,
    output logic [LOCAL_W-1:0]         out_neuron,
    output logic [WEIGHT_W-1:0]        out_weight,
    output logic                       out_exc
);
    localparam int SRC_W   = GROUP_W + LOCAL_W;
    localparam int PAY_W   = GROUP_W + LOCAL_W + WEIGHT_W + 1;
    localparam int ENTRY_W = PAY_W + 1;
    localparam int ROW_W   = ENTRY_W << SLOT_W;

    logic [ENTRY_W-1:0] wr_entry;
    logic [ROW_W-1:0]   rd_row;
    logic               rd_en;
    logic [PAY_W-1:0]   payload;

    // Entry layout, MSB first: live, group, neuron, weight, exc.
    assign wr_entry = {wr_live, wr_dst_group, wr_dst_neuron, wr_weight, wr_exc};

    sfr_slot_table #(
        .SRC_W   (SRC_W),
        .SLOT_W  (SLOT_W),
        .ENTRY_W (ENTRY_W)
    ) u_table (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_src   (wr_src),
        .wr_slot  (wr_slot),
        .wr_entry (wr_entry),
        .rd_en    (rd_en),
        .rd_src   (in_src),
        .rd_row   (rd_row)
    );

    sfr_scan_fsm #(
        .SLOT_W  (SLOT_W),
        .ENTRY_W (ENTRY_W)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .rd_en       (rd_en),
        .rd_row      (rd_row),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_payload (payload)
    );

    assign {out_group, out_neuron, out_weight, out_exc} = payload;

    // No spike is taken while a delivery is pending (R4).
    p_busy_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready)
        else $error("p_busy_block_r4");

    // Fetch cycle follows acceptance: nothing offered, nothing taken (R7).
    p_fetch_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid))
        else $error("p_fetch_gap_r7");

    // Stalled delivery holds (R5).
    p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> (out_valid && $stable({out_group, out_neuron, out_weight, out_exc})))
        else $error("p_hold_stall_r5");

endmodule

// File: tb/sim_spike_fanout_router.sv
`timescale 1ns/1ps
module sim_spike_fanout_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [10:0] in_src = '0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_src = '0;
    logic [3:0]  wr_slot = '0;
    logic [3:0]  wr_dst_group = '0;
    logic [6:0]  wr_dst_neuron = '0;
    logic [7:0]  wr_weight = '0;
    logic        wr_exc = 1'b0;
    logic        wr_live = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  out_group;
    logic [6:0]  out_neuron;
    logic [7:0]  out_weight;
    logic        out_exc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench-side table model, key = src*16 + slot.
    bit      m_live [int];
    bit [19:0] m_pay [int];

    // Mid-scan write request used by the snapshot test.
    bit        mid_en = 0;
    int        mid_slot = 0;
    bit [19:0] mid_pay = '0;

    always #2.5 clk = ~clk;

    spike_fanout_router u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
        .wr_en(wr_en), .wr_src(wr_src), .wr_slot(wr_slot),
        .wr_dst_group(wr_dst_group), .wr_dst_neuron(wr_dst_neuron),
        .wr_weight(wr_weight), .wr_exc(wr_exc), .wr_live(wr_live),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_group(out_group), .out_neuron(out_neuron),
        .out_weight(out_weight), .out_exc(out_exc)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int pay_now();
        return int'({out_group, out_neuron, out_weight, out_exc});
    endfunction

    // Called at a negedge; returns at a negedge.
    task automatic write_entry(int src, int slot, bit live, bit [19:0] pay);
        wr_en = 1'b1;
        wr_src = 11'(src);
        wr_slot = 4'(slot);
        wr_live = live;
        {wr_dst_group, wr_dst_neuron, wr_weight, wr_exc} = pay;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        m_live[src*16 + slot] = live;
        m_pay[src*16 + slot] = pay;
    endtask

    task automatic clear_src(int src);
        for (int s = 0; s < 16; s++) write_entry(src, s, 1'b0, 20'h0);
    endtask

    function automatic bit [19:0] mkpay(int g, int n, int w, bit e);
        return {4'(g), 7'(n), 8'(w), e};
    endfunction

    // Sends one spike from src and checks every delivery it produces.
    task automatic run_spike(int src, bit stall, string tag);
        bit        snap_l [16];
        bit [19:0] snap_p [16];
        int        n = 0;
        bit        first = 1;
        for (int s = 0; s < 16; s++) begin
            snap_l[s] = m_live[src*16 + s];
            snap_p[s] = m_pay[src*16 + s];
            if (snap_l[s]) n++;
        end
        in_src = 11'(src);
        in_valid = 1'b1;
        chk({tag, " R4 ready before spike"}, int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R7 no delivery in fetch"}, int'(out_valid), 0);
        chk({tag, " R4 busy in fetch"}, int'(in_ready), 0);
        @(negedge clk);
        if (n == 0) begin
            chk({tag, " R6 no delivery"}, int'(out_valid), 0);
            chk({tag, " R6 ready again"}, int'(in_ready), 1);
            return;
        end
        for (int s = 0; s < 16; s++) begin
            if (snap_l[s]) begin
                chk({tag, " R7 R2 delivery valid"}, int'(out_valid), 1);
                chk({tag, " R3 fields"}, pay_now(), int'(snap_p[s]));
                chk({tag, " R4 busy during scan"}, int'(in_ready), 0);
                if (stall && first) begin
                    out_ready = 1'b0;
                    for (int c = 0; c < 3; c++) begin
                        if (mid_en && c == 0)
                            write_entry(src, mid_slot, 1'b1, mid_pay);
                        else begin
                            @(posedge clk);
                            @(negedge clk);
                        end
                        chk({tag, " R5 valid held"}, int'(out_valid), 1);
                        chk({tag, " R5 fields held"}, pay_now(), int'(snap_p[s]));
                        chk({tag, " R4 busy in stall"}, int'(in_ready), 0);
                    end
                    out_ready = 1'b1;
                end
                first = 0;
                @(posedge clk);
                @(negedge clk);
            end
        end
        chk({tag, " R2 no extra delivery"}, int'(out_valid), 0);
        chk({tag, " R4 ready after last"}, int'(in_ready), 1);
    endtask

    localparam int SRC_A = (3 << 7) | 5;
    localparam int SRC_B = (9 << 7) | 5;
    localparam int SRC_C = (0 << 7) | 100;
    localparam int SRC_D = (15 << 7) | 127;
    localparam int SRC_E = (7 << 7) | 1;

    task automatic t_reset();
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_sparse();
        clear_src(SRC_A);
        write_entry(SRC_A, 2, 1'b1, mkpay(1, 10, 7, 1'b1));
        write_entry(SRC_A, 4, 1'b0, mkpay(2, 20, 9, 1'b1));
        write_entry(SRC_A, 7, 1'b1, mkpay(6, 99, 200, 1'b0));
        write_entry(SRC_A, 15, 1'b1, mkpay(15, 127, 255, 1'b1));
        run_spike(SRC_A, 1'b0, "sparse");
    endtask

    task automatic t_empty();
        clear_src(SRC_C);
        run_spike(SRC_C, 1'b0, "empty");
    endtask

    task automatic t_full();
        clear_src(SRC_D);
        for (int s = 0; s < 16; s++)
            write_entry(SRC_D, s, 1'b1, mkpay(s, 3 * s + 1, 16 * s + 5, s[0]));
        run_spike(SRC_D, 1'b0, "full R10");
    endtask

    task automatic t_stall();
        run_spike(SRC_A, 1'b1, "stall");
    endtask

    task automatic t_snapshot();
        clear_src(SRC_E);
        write_entry(SRC_E, 0, 1'b1, mkpay(4, 40, 44, 1'b1));
        write_entry(SRC_E, 1, 1'b1, mkpay(5, 50, 55, 1'b0));
        mid_en = 1;
        mid_slot = 1;
        mid_pay = mkpay(12, 77, 133, 1'b1);
        run_spike(SRC_E, 1'b1, "R8 in flight");
        mid_en = 0;
        run_spike(SRC_E, 1'b0, "R8 next spike");
    endtask

    task automatic t_overwrite();
        write_entry(SRC_A, 7, 1'b1, mkpay(8, 8, 8, 1'b1));
        run_spike(SRC_A, 1'b0, "R9 one slot changed");
        run_spike(SRC_D, 1'b0, "R9 other source intact");
    endtask

    task automatic t_group_alias();
        clear_src(SRC_B);
        write_entry(SRC_B, 2, 1'b1, mkpay(3, 3, 3, 1'b0));
        run_spike(SRC_B, 1'b0, "R11 upper group");
        run_spike(SRC_A, 1'b0, "R11 lower group unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sparse();
        t_empty();
        t_full();
        t_stall();
        t_snapshot();
        t_overwrite();
        t_group_alias();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule